// File: doc/BRIEF.md
# PLL Setting Search Engine

This block takes a reference frequency and a target frequency, both plain integers in the same unit (normally Hz). It searches for the PLL setting whose output frequency comes closest to the target without exceeding it. A setting has three fields: an 8-bit multiplier field `m`, a 1-bit pre-divider field `p` and a 3-bit post-divider exponent `q`. The output frequency of a setting is `floor(ref * (m+1) / ((p+1) * 2^q))`.

Candidates are visited one per clock in a fixed order. A search ends early on the first exact hit. When it finishes, the block returns a packed configuration word, the achieved frequency and a flag that says no setting can reach the target. The word also carries a loop-filter range code. The code comes from the reference frequency expressed in whole MHz after the pre-divider.

A request is a single transfer on a valid/ready channel, and so is the answer. `req_ready` is high only while the block is idle, so a request waits until the previous answer has been taken. The answer stays presented, and unchanged, until the consumer raises `res_ready`. The output registers then keep their values until the next request is accepted. A search takes at most about 4100 cycles.

Top module: `pll_setting_search`

## Requirements
- R1: A request is accepted on a clock edge with `req_valid` and `req_ready` both high, and `req_ref` and `req_target` are captured at that edge. `req_ready` is high only while idle: it is low from the cycle after acceptance until the answer has been consumed.
- R2: `res_valid` stays high until a cycle with `res_ready` high. While it waits, `res_word`, `res_freq` and `res_impossible` do not change. After the answer is consumed, the outputs keep their values until the next acceptance.
- R3: The output frequency of a candidate is `floor(ref*(m+1) / ((p+1)*2^q))`, with m in 0..255, p in 0..1 and q in 0..7.
- R4: The chosen setting never exceeds the target, and its error is the smallest over all candidates. `res_freq` equals the target minus that error.
- R5: The visiting order is p from 1 down to 0, then q from 7 down to 0, then m from 0 up to 255 (innermost). A later candidate replaces the stored best only when its error is strictly smaller, so among equal errors the earliest candidate is reported.
- R6: A candidate with zero error ends the search, and the first exact candidate in the order of R5 is reported.
- R7: When no candidate is at or below the target, `res_impossible` is 1 and `res_word` and `res_freq` are 0. Otherwise `res_impossible` is 0.
- R8: The filter code uses `f = floor(floor(ref / REF_UNIT) / (p+1))` with the chosen p. The code is 7 if f >= 166, 6 if f >= 104, 5 if f >= 65, 4 if f >= 42, 3 if f >= 26, 2 if f >= 16, 1 if f >= 10, and 0 otherwise.
- R9: The layout of `res_word` is: filter code in bits 31:24, m in bits 23:16, p in bit 8 and q in bits 2:0. All other bits are zero.
- R10: After reset, `req_ready` is 1, `res_valid` is 0, and `res_word`, `res_freq` and `res_impossible` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_ref | input | FREQ_W | Reference frequency |
| req_target | input | FREQ_W | Target frequency |
| res_valid | output | 1 | Answer present |
| res_ready | input | 1 | Consumer takes the answer |
| res_word | output | 32 | Packed setting and filter code |
| res_freq | output | FREQ_W | Achieved frequency |
| res_impossible | output | 1 | No setting reaches the target |

## Verification
The hardest situation to reach is one where several settings produce the same output. The report must then name the earliest of them and not a later one with an equal value. A directed request with a reference of 256 and a target of 1000 has several exact settings spread over different rows. The bench checks the packed word against the one expected value (p=1, q=5, m=249).

A reference of 1000 with a target of 2 lies below every reachable output and drives the impossible path. References of 50 MHz and 400 MHz pin down two filter codes. Random pairs are drawn from a fixed seed and compared with a bench model that walks the full candidate space.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int MUL_W   = 8;
  localparam int PRE_W   = 1;
  localparam int POST_W  = 3;
  localparam int SHIFT_W = 4;
  localparam int FILT_W  = 3;
  localparam int WORD_W  = 32;

  typedef struct packed {
    logic [MUL_W-1:0]  mul;
    logic [PRE_W-1:0]  pre;
    logic [POST_W-1:0] post;
  } pll_setting_t;

  function automatic logic [WORD_W-1:0] pack_setting(input logic [FILT_W-1:0] filt,
                                                     input pll_setting_t s);
    return {5'd0, filt, s.mul, 7'd0, s.pre, 5'd0, s.post};
  endfunction
endpackage

// File: rtl/pll_unit_divider.sv
module pll_unit_divider #(
  parameter int W       = 32,
  parameter int DIVISOR = 1000000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  output logic         busy,
  output logic [W-1:0] quotient
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [W:0] DIV_V = (W+1)'(DIVISOR);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(W);

  logic [W-1:0]     rem_q;
  logic [W-1:0]     quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W:0]       trial;
  logic             fits;

  assign trial = {rem_q, quo_q[W-1]};
  assign fits  = trial >= DIV_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      rem_q <= '0;
      quo_q <= dividend;
      cnt_q <= CNT_INIT;
      busy  <= 1'b1;
    end else if (busy) begin
      if (fits) begin
        rem_q <= W'(trial - DIV_V);
      end else begin
        rem_q <= trial[W-1:0];
      end
      quo_q <= {quo_q[W-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) busy <= 1'b0;
    end
  end

  assign quotient = quo_q;
endmodule

// File: rtl/pll_cand_walker.sv
module pll_cand_walker
  import pll_search_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [FREQ_W-1:0]       ref_in,
  input  logic                    step,
  input  logic                    jump,
  output pll_setting_t            cur,
  output logic [FREQ_W+MUL_W-1:0] cand,
  output logic                    last_row,
  output logic                    last_col
);
  localparam int ACC_W = FREQ_W + MUL_W;

  logic [FREQ_W-1:0] ref_q;
  logic [ACC_W-1:0]  acc_q;
  logic [SHIFT_W-1:0] shamt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= '0;
      acc_q    <= '0;
      cur.mul  <= '0;
      cur.pre  <= '1;
      cur.post <= '1;
    end else if (load) begin
      ref_q    <= ref_in;
      acc_q    <= ACC_W'(ref_in);
      cur.mul  <= '0;
      cur.pre  <= '1;
      cur.post <= '1;
    end else if (jump) begin
      acc_q   <= ACC_W'(ref_q);
      cur.mul <= '0;
      if (cur.post == '0) begin
        cur.post <= '1;
        cur.pre  <= cur.pre - 1'b1;
      end else begin
        cur.post <= cur.post - 1'b1;
      end
    end else if (step) begin
      acc_q   <= acc_q + ACC_W'(ref_q);
      cur.mul <= cur.mul + 1'b1;
    end
  end

  assign shamt    = SHIFT_W'(cur.pre) + SHIFT_W'(cur.post);
  assign cand     = acc_q >> shamt;
  assign last_row = (cur.pre == '0) && (cur.post == '0);
  assign last_col = (cur.mul == '1);
endmodule

// File: rtl/pll_best_keeper.sv
module pll_best_keeper
  import pll_search_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              offer,
  input  logic [FREQ_W-1:0] err,
  input  pll_setting_t      setting,
  output logic              found,
  output logic [FREQ_W-1:0] best_err,
  output pll_setting_t      best
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found    <= 1'b0;
      best_err <= '0;
      best     <= '0;
    end else if (clear) begin
      found    <= 1'b0;
      best_err <= '0;
      best     <= '0;
    end else if (offer && (!found || err < best_err)) begin
      found    <= 1'b1;
      best_err <= err;
      best     <= setting;
    end
  end
endmodule

// File: rtl/pll_filter_code.sv
module pll_filter_code
  import pll_search_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic [FREQ_W-1:0] mhz,
  input  logic [PRE_W-1:0]  pre,
  output logic [FILT_W-1:0] code
);
  logic [FREQ_W-1:0] f;
  assign f = mhz >> pre;

  always_comb begin
    if      (f >= FREQ_W'(166)) code = 3'd7;
    else if (f >= FREQ_W'(104)) code = 3'd6;
    else if (f >= FREQ_W'(65))  code = 3'd5;
    else if (f >= FREQ_W'(42))  code = 3'd4;
    else if (f >= FREQ_W'(26))  code = 3'd3;
    else if (f >= FREQ_W'(16))  code = 3'd2;
    else if (f >= FREQ_W'(10))  code = 3'd1;
    else                        code = 3'd0;
  end
endmodule

// File: rtl/pll_setting_search.sv
module pll_setting_search
  import pll_search_pkg::*;
#(
  parameter int FREQ_W   = 32,
  parameter int REF_UNIT = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FREQ_W-1:0] req_ref,
  input  logic [FREQ_W-1:0] req_target,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_word,
  output logic [FREQ_W-1:0] res_freq,
  output logic              res_impossible
);
  localparam int ACC_W = FREQ_W + MUL_W;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_OUT} state_t;

  state_t            state_q;
  logic              live_q;
  logic [FREQ_W-1:0] target_q;

  logic              accept;
  logic              searching;
  pll_setting_t      cur;
  logic [ACC_W-1:0]  cand;
  logic              last_row, last_col;
  logic              in_range, exact, row_end, finish_search;
  logic              w_step, w_jump;
  logic [FREQ_W-1:0] err;
  logic              found;
  logic [FREQ_W-1:0] best_err;
  pll_setting_t      best;
  logic              div_busy;
  logic [FREQ_W-1:0] ref_mhz;
  logic [FILT_W-1:0] filt;

  assign req_ready = (state_q == ST_IDLE);
  assign res_valid = (state_q == ST_OUT);
  assign accept    = req_valid && req_ready;
  assign searching = (state_q == ST_RUN) && live_q;

  assign in_range      = cand <= ACC_W'(target_q);
  assign err           = target_q - cand[FREQ_W-1:0];
  assign exact         = in_range && (err == '0);
  assign row_end       = !in_range || last_col;
  assign finish_search = searching && (exact || (row_end && last_row));
  assign w_step        = searching && !exact && !row_end;
  assign w_jump        = searching && !exact && row_end && !last_row;

  pll_cand_walker #(.FREQ_W(FREQ_W)) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .ref_in   (req_ref),
    .step     (w_step),
    .jump     (w_jump),
    .cur      (cur),
    .cand     (cand),
    .last_row (last_row),
    .last_col (last_col)
  );

  pll_best_keeper #(.FREQ_W(FREQ_W)) u_keeper (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .offer    (searching && in_range),
    .err      (err),
    .setting  (cur),
    .found    (found),
    .best_err (best_err),
    .best     (best)
  );

  pll_unit_divider #(.W(FREQ_W), .DIVISOR(REF_UNIT)) u_mhz (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .dividend (req_ref),
    .busy     (div_busy),
    .quotient (ref_mhz)
  );

  pll_filter_code #(.FREQ_W(FREQ_W)) u_filter (
    .mhz  (ref_mhz),
    .pre  (best.pre),
    .code (filt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      live_q         <= 1'b0;
      target_q       <= '0;
      res_word       <= '0;
      res_freq       <= '0;
      res_impossible <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            target_q <= req_target;
            live_q   <= 1'b1;
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (finish_search) live_q <= 1'b0;
          if (!live_q && !div_busy) begin
            res_impossible <= !found;
            res_word       <= found ? pack_setting(filt, best) : '0;
            res_freq       <= found ? (target_q - best_err) : '0;
            state_q        <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (res_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_search_checker.sv
module pll_search_checker #(
  parameter int FREQ_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [FREQ_W-1:0] req_target,
  input logic              res_valid,
  input logic              res_ready,
  input logic [31:0]       res_word,
  input logic [FREQ_W-1:0] res_freq,
  input logic              res_impossible
);
  logic [FREQ_W-1:0] tgt_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_cap <= '0;
    else if (req_valid && req_ready) tgt_cap <= req_target;
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r1_no_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  a_r2_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_word) && $stable(res_freq)
                                && $stable(res_impossible));

  a_r4_not_above_target: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_freq <= tgt_cap);

  a_r7_impossible_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_impossible |-> res_word == 32'd0 && res_freq == '0);

  a_r9_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_word[31:27] == 5'd0 && res_word[15:9] == 7'd0 && res_word[7:3] == 5'd0);
endmodule

bind pll_setting_search pll_search_checker #(.FREQ_W(FREQ_W)) u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_target     (req_target),
  .res_valid      (res_valid),
  .res_ready      (res_ready),
  .res_word       (res_word),
  .res_freq       (res_freq),
  .res_impossible (res_impossible)
);

// File: tb/test_pll_setting_search.sv
`timescale 1ns/1ps
module test_pll_setting_search;
  localparam int FW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [FW-1:0] req_ref = '0;
  logic [FW-1:0] req_target = '0;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [31:0]   res_word;
  logic [FW-1:0] res_freq;
  logic          res_impossible;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pll_setting_search i_pll_setting_search (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_ref(req_ref), .req_target(req_target),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_word(res_word), .res_freq(res_freq), .res_impossible(res_impossible)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic int filt_of(input longint mhz);
    if (mhz >= 166) return 7;
    if (mhz >= 104) return 6;
    if (mhz >= 65)  return 5;
    if (mhz >= 42)  return 4;
    if (mhz >= 26)  return 3;
    if (mhz >= 16)  return 2;
    if (mhz >= 10)  return 1;
    return 0;
  endfunction

  // Reference model of R3..R9: full ordered walk, strict improvement, exact exit.
  function automatic void model(input longint rf, input longint tg,
                                output logic [31:0] word, output longint freq, output bit imp);
    bit found = 0;
    bit stop  = 0;
    longint best_err = 0;
    int bp = 0, bq = 0, bm = 0;
    for (int p = 1; p >= 0 && !stop; p--)
      for (int q = 7; q >= 0 && !stop; q--)
        for (int m = 0; m <= 255 && !stop; m++) begin
          longint c = (rf * (m + 1)) >>> (p + q);
          if (c <= tg) begin
            longint e = tg - c;
            if (!found || e < best_err) begin
              found = 1; best_err = e; bp = p; bq = q; bm = m;
            end
            if (e == 0) stop = 1;
          end
        end
    imp = !found;
    if (found) begin
      int fc = filt_of((rf / 1000000) >>> bp);
      word = {8'(fc), 8'(bm), 7'd0, 1'(bp), 5'd0, 3'(bq)};
      freq = tg - best_err;
    end else begin
      word = '0;
      freq = 0;
    end
  endfunction

  task automatic run(input longint rf, input longint tg, input int hold, input string tag);
    logic [31:0] ew; longint ef; bit ei;
    logic [31:0] w0; longint f0;
    model(rf, tg, ew, ef, ei);
    @(negedge clk);
    req_valid  = 1'b1;
    req_ref    = FW'(rf);
    req_target = FW'(tg);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid  = 1'b0;
    req_ref    = '1;
    req_target = '1;
    check(!req_ready, {"R1 ready low while searching ", tag}, req_ready, 0);
    while (!res_valid) @(negedge clk);
    check(res_word == ew, {"R4 R5 R6 R8 R9 word ", tag}, res_word, ew);
    check(res_freq == FW'(ef), {"R4 freq ", tag}, res_freq, ef);
    check(res_impossible == ei, {"R7 flag ", tag}, res_impossible, ei);
    w0 = res_word; f0 = res_freq;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(res_valid && res_word == w0 && res_freq == FW'(f0),
            {"R2 held while not ready ", tag}, res_word, w0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(!res_valid && req_ready, {"R2 consumed ", tag}, res_valid, 0);
    @(negedge clk);
    check(res_word == w0 && res_freq == FW'(f0), {"R2 kept after consume ", tag}, res_word, w0);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && res_valid == 1'b0, "R10 handshake at reset", res_valid, 0);
    check(res_word == 0 && res_freq == 0 && res_impossible == 0, "R10 outputs at reset", res_word, 0);
    rst_n = 1'b1;

    // R5 R6: earliest of several exact settings (p=1,q=5,m=249)
    run(256, 1000, 2, "tie");
    check(res_word == 32'h00F9_0105, "R5 earliest exact setting", res_word, 32'h00F9_0105);
    // R7: below every reachable output
    run(1000, 2, 1, "impossible");
    check(res_impossible == 1'b1, "R7 impossible flag", res_impossible, 1);
    // R3 R6: tiny reference, zero target is exact at first candidate
    run(100, 0, 0, "zero target");
    check(res_word == 32'h0000_0107 && res_freq == 0, "R3 first candidate", res_word, 32'h0000_0107);
    // R8: filter codes with p=1
    run(400000000, 400000000, 0, "filt7");
    check(res_word == 32'h07FF_0107, "R8 code 7", res_word, 32'h07FF_0107);
    run(50000000, 50000000, 0, "filt2");
    check(res_word == 32'h02FF_0107, "R8 code 2", res_word, 32'h02FF_0107);
    // R4: target above every output, best is the largest one
    run(1000, 32'hFFFF_FFFF, 1, "all below");
    check(res_freq == 256000, "R4 largest output", res_freq, 256000);
    run(25000000, 600000000, 0, "typical");

    for (int k = 0; k < 18; k++) begin
      longint rf = longint'($urandom_range(32'h7FFF_FFFF, 1));
      longint tg = longint'($urandom());
      if (k % 3 == 0) tg = (rf * longint'($urandom_range(255, 1))) >>> $urandom_range(8, 0);
      if (tg > 64'hFFFF_FFFF) tg = 64'hFFFF_FFFF;
      run(rf, tg, k % 3, "random");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule